// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller. In its default build it serves 64 pins, split into two 32-bit register sets. Each pin has a direction bit. Its output level changes only through a write-one-to-set port and a write-one-to-clear port, so software never needs a read-modify-write to change an output. The live pin level can always be read back through a two-flop synchronizer.

Each pin can detect rising edges, falling edges, or both. A detected edge latches into a write-one-to-clear status word. Every 32-bit set feeds two 16-pin interrupt banks: the low half goes to the even bank and the high half to the odd bank. Each bank drives one interrupt line, which is the OR of its status bits gated by that bank's enable bit.

Software accesses the block over a simple 32-bit register bus. Reads return their data one cycle after the read strobe.

Register map:
- Bank enable register at byte 0x08. Bit n enables interrupt line n.
- Set s starts at byte 0x10 + 0x28*s.
- Within a set, the words are at these byte offsets: direction +0x00, output data +0x04, set-output +0x08, clear-output +0x0C, input level +0x10, set-rise +0x14, clear-rise +0x18, set-fall +0x1C, clear-fall +0x20, status +0x24.
- Pin p belongs to set p/32, at bit p%32 of that set.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every direction bit reads 1, and every pin output enable is low. Output data, edge enables, status and the bank enables all read 0, and every interrupt line is low.
- R2: A direction bit of 1 makes the pin an input (output enable low). A direction bit of 0 makes it an output (output enable high). The direction word at +0x00 is read/write.
- R3: Writing a mask to +0x08 drives the selected output bits high, and writing a mask to +0x0C drives them low. Zero bits in the mask leave their outputs as they were. Writes to the output data word at +0x04 are ignored.
- R4: The input word at +0x10 returns the pin levels after a two-flop synchronizer, whatever the direction of the pin. Writes to it are ignored.
- R5: Writing ones to +0x14 or +0x1C enables rising or falling detection for those bits, and writing ones to +0x18 or +0x20 disables it. Reads of +0x14/+0x18 return the rise enables, reads of +0x1C/+0x20 return the fall enables, and reads of +0x08/+0x0C return the output data.
- R6: An edge in an enabled direction sets the pin's status bit. The bit is set at the third rising clock edge after the pin changes. An edge in a direction that is not enabled leaves the status unchanged.
- R7: Writing ones to the status word at +0x24 clears those bits. If a new enabled edge is detected in the same cycle as the clear, the bit stays set.
- R8: Interrupt line 2s is the OR of status bits 15:0 of set s, and line 2s+1 is the OR of bits 31:16. Each line is gated by its own bit of the bank enable register at 0x08, which is read/write.
- R9: A read returns its data on bus_rdata one cycle after bus_ren. Reads of unmapped or unaligned offsets return 0.
- R10: bus_rdata holds its last value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wen | input | 1 | Write strobe |
| bus_ren | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 64 | Pin levels from the pads |
| pin_out | output | 64 | Output levels to the pads |
| pin_oe | output | 64 | Per-pin output enable |
| irq | output | 4 | One interrupt line per 16-pin bank |

## Verification
Several properties are checked on every cycle:
- a set-port or clear-port write forces the masked outputs one cycle later;
- outputs stay unchanged in cycles without such a write;
- a status bit only falls in the cycle after a write-one-to-clear covering that bit;
- a disabled bank never raises its line;
- unmapped reads return zero.

Other behaviour only the bench scenarios can show: the exact synchronizer delay before a status bit sets, and the race between an edge and a clear in the same cycle. The same holds for edges in a disabled direction being ignored, and for input readback of a pin driven as an output. A bench reference model runs alongside the random traffic and compares the outputs, the interrupts and the read data on every cycle.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   // Word index inside one register set; the order fixes the address layout.
   typedef enum logic [3:0] {
      W_DIR  = 4'd0,
      W_OUT  = 4'd1,
      W_SET  = 4'd2,
      W_CLR  = 4'd3,
      W_IN   = 4'd4,
      W_SETR = 4'd5,
      W_CLRR = 4'd6,
      W_SETF = 4'd7,
      W_CLRF = 4'd8,
      W_STAT = 4'd9
   } word_e;

   localparam int WORDS_PER_SET = 10;
   localparam int SET_SPAN      = WORDS_PER_SET * 4;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import gpio_edge_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int NUM_SETS   = 2,
   parameter int SET_BASE   = 16,
   parameter int SET_STRIDE = 40,
   parameter int BEN_OFS    = 8
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_SETS-1:0] set_hit,
   output word_e               word,
   output logic                ben_hit
);

   always_comb begin
      int a;
      int lo;
      a       = int'(addr);
      set_hit = '0;
      word    = W_DIR;
      for (int s = 0; s < NUM_SETS; s++) begin
         lo = SET_BASE + s * SET_STRIDE;
         if (a >= lo && a < lo + SET_SPAN && a[1:0] == 2'b00) begin
            set_hit[s] = 1'b1;
            word       = word_e'(4'((a - lo) / 4));
         end
      end
      ben_hit = (a == BEN_OFS);
   end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 64,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync needs at least two stages");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stg[i] <= '0;
               else        stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpio_regset.sv
module gpio_regset
   import gpio_edge_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  word_e        word,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pin_s,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] out_q,
   output logic [W-1:0] stat_q,
   output logic [W-1:0] rd_val
);

   logic [W-1:0] rise_q;
   logic [W-1:0] fall_q;
   logic [W-1:0] prev_q;
   logic [W-1:0] edges;
   logic [W-1:0] w1c;

   assign edges = (pin_s & ~prev_q & rise_q) | (~pin_s & prev_q & fall_q);
   assign w1c   = (wr_en && word == W_STAT) ? wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q  <= '1;
         out_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
         prev_q <= '0;
         stat_q <= '0;
      end else begin
         prev_q <= pin_s;
         stat_q <= (stat_q & ~w1c) | edges;
         if (wr_en) begin
            case (word)
               W_DIR:   dir_q  <= wdata;
               W_SET:   out_q  <= out_q | wdata;
               W_CLR:   out_q  <= out_q & ~wdata;
               W_SETR:  rise_q <= rise_q | wdata;
               W_CLRR:  rise_q <= rise_q & ~wdata;
               W_SETF:  fall_q <= fall_q | wdata;
               W_CLRF:  fall_q <= fall_q & ~wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (word)
         W_DIR:                rd_val = dir_q;
         W_OUT, W_SET, W_CLR:  rd_val = out_q;
         W_IN:                 rd_val = pin_s;
         W_SETR, W_CLRR:       rd_val = rise_q;
         W_SETF, W_CLRF:       rd_val = fall_q;
         W_STAT:               rd_val = stat_q;
         default:              rd_val = '0;
      endcase
   end

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
   parameter int BANK_W = 16,
   parameter int NBANKS = 4
) (
   input  logic [NBANKS*BANK_W-1:0] stat,
   input  logic [NBANKS-1:0]        en,
   output logic [NBANKS-1:0]        irq
);

   generate
      for (genvar b = 0; b < NBANKS; b++) begin : g_bank
         assign irq[b] = en[b] & (|stat[b*BANK_W +: BANK_W]);
      end
   endgenerate

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
   import gpio_edge_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int REG_W       = 32,
   parameter int NUM_SETS    = 2,
   parameter int BANK_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int SET_BASE    = 16,
   parameter int SET_STRIDE  = 40,
   parameter int BEN_OFS     = 8,
   localparam int NPINS      = NUM_SETS * REG_W,
   localparam int NBANKS     = NPINS / BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic              bus_ren,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic [NBANKS-1:0] irq
);

   generate
      if (REG_W % BANK_W != 0) begin : g_bad_bank
         $error("REG_W must be a multiple of BANK_W");
      end
      if (SET_STRIDE < SET_SPAN || SET_STRIDE % 4 != 0) begin : g_bad_stride
         $error("SET_STRIDE must be word aligned and cover one set");
      end
      if (NBANKS > REG_W) begin : g_bad_nbanks
         $error("bank enable register cannot hold all banks");
      end
      if (SET_BASE + NUM_SETS * SET_STRIDE > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   logic [NUM_SETS-1:0] set_hit;
   word_e               word;
   logic                ben_hit;
   logic [NPINS-1:0]    pin_s;
   logic [NPINS-1:0]    dir_all;
   logic [NPINS-1:0]    stat_all;
   logic [REG_W-1:0]    rd_set [NUM_SETS];
   logic [NBANKS-1:0]   ben_q;
   logic [REG_W-1:0]    rd_next;

   gpio_addr_dec #(
      .ADDR_W     (ADDR_W),
      .NUM_SETS   (NUM_SETS),
      .SET_BASE   (SET_BASE),
      .SET_STRIDE (SET_STRIDE),
      .BEN_OFS    (BEN_OFS)
   ) u_dec (
      .addr    (bus_addr),
      .set_hit (set_hit),
      .word    (word),
      .ben_hit (ben_hit)
   );

   gpio_sync #(
      .W      (NPINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pin_in),
      .dout  (pin_s)
   );

   generate
      for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
         gpio_regset #(.W(REG_W)) u_set (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bus_wen & set_hit[s]),
            .word   (word),
            .wdata  (bus_wdata),
            .pin_s  (pin_s[s*REG_W +: REG_W]),
            .dir_q  (dir_all[s*REG_W +: REG_W]),
            .out_q  (pin_out[s*REG_W +: REG_W]),
            .stat_q (stat_all[s*REG_W +: REG_W]),
            .rd_val (rd_set[s])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                 ben_q <= '0;
      else if (bus_wen && ben_hit) ben_q <= bus_wdata[NBANKS-1:0];
   end

   gpio_bank_irq #(
      .BANK_W (BANK_W),
      .NBANKS (NBANKS)
   ) u_irq (
      .stat (stat_all),
      .en   (ben_q),
      .irq  (irq)
   );

   always_comb begin
      rd_next = '0;
      if (ben_hit) rd_next[NBANKS-1:0] = ben_q;
      for (int s = 0; s < NUM_SETS; s++) begin
         if (set_hit[s]) rd_next = rd_set[s];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       bus_rdata <= '0;
      else if (bus_ren) bus_rdata <= rd_next;
   end

   assign pin_oe = ~dir_all;

endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk #(
   parameter int ADDR_W     = 8,
   parameter int REG_W      = 32,
   parameter int NUM_SETS   = 2,
   parameter int NBANKS     = 4,
   parameter int SET_BASE   = 16,
   parameter int SET_STRIDE = 40,
   parameter int BEN_OFS    = 8,
   localparam int NPINS     = NUM_SETS * REG_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wen,
   input logic              bus_ren,
   input logic [REG_W-1:0]  bus_wdata,
   input logic [REG_W-1:0]  bus_rdata,
   input logic [NPINS-1:0]  pin_out,
   input logic [NPINS-1:0]  pin_oe,
   input logic [NBANKS-1:0] irq,
   input logic [NPINS-1:0]  stat_all,
   input logic [NBANKS-1:0] ben_q
);

   logic [NPINS-1:0] set_mask;
   logic [NPINS-1:0] clr_mask;
   logic [NPINS-1:0] w1c_mask;
   logic             mapped;

   always_comb begin
      int a;
      int lo;
      a        = int'(bus_addr);
      set_mask = '0;
      clr_mask = '0;
      w1c_mask = '0;
      mapped   = (a == BEN_OFS);
      for (int s = 0; s < NUM_SETS; s++) begin
         lo = SET_BASE + s * SET_STRIDE;
         if (a >= lo && a < lo + 40 && a[1:0] == 2'b00) mapped = 1'b1;
         if (bus_wen && a == lo + 8)  set_mask[s*REG_W +: REG_W] = bus_wdata;
         if (bus_wen && a == lo + 12) clr_mask[s*REG_W +: REG_W] = bus_wdata;
         if (bus_wen && a == lo + 36) w1c_mask[s*REG_W +: REG_W] = bus_wdata;
      end
   end

   // R1: state seen right after reset is released
   a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && irq == '0));

   a_r3_set_port: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_mask) |=> ((pin_out & $past(set_mask)) == $past(set_mask)));

   a_r3_clr_port: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_mask) |=> ((pin_out & $past(clr_mask)) == '0));

   a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !((|set_mask) || (|clr_mask)) |=> $stable(pin_out));

   a_r7_fall_only_on_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(stat_all) & ~stat_all & ~$past(w1c_mask)) == '0));

   a_r8_bank_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq & ~ben_q) == '0));

   a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ren && !mapped) |=> (bus_rdata == '0));

   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ren |=> $stable(bus_rdata));

endmodule

bind gpio_edge_ctrl gpio_edge_chk #(
   .ADDR_W     (ADDR_W),
   .REG_W      (REG_W),
   .NUM_SETS   (NUM_SETS),
   .NBANKS     (NBANKS),
   .SET_BASE   (SET_BASE),
   .SET_STRIDE (SET_STRIDE),
   .BEN_OFS    (BEN_OFS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wen   (bus_wen),
   .bus_ren   (bus_ren),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq       (irq),
   .stat_all  (stat_all),
   .ben_q     (ben_q)
);

// File: tb/tb_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_edge_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wen = 1'b0;
   logic        bus_ren = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] pin_in = '0;
   logic [63:0] pin_out;
   logic [63:0] pin_oe;
   logic [3:0]  irq;

   int total = 0;
   int fails = 0;
   int cyc = 0;
   bit cmp_on = 1'b0;

   always #2.5 clk = ~clk;

   gpio_edge_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
      .bus_ren(bus_ren), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   // Reference model built from the requirements
   logic [63:0] m_dir, m_out, m_rise, m_fall, m_stat, m_s1, m_s2, m_prev;
   logic [3:0]  m_ben;
   logic [31:0] m_rd;

   // returns -1 unmapped, 100 bank enable, else set*10+word
   function automatic int decode(input logic [7:0] a);
      int v = int'(a);
      if (v == 8) return 100;
      if (v >= 16 && v < 96 && v[1:0] == 2'b00)
         return ((v - 16) / 40) * 10 + ((v - 16) % 40) / 4;
      return -1;
   endfunction

   function automatic logic [3:0] model_irq(input logic [63:0] st, input logic [3:0] en);
      logic [3:0] r;
      for (int b = 0; b < 4; b++) r[b] = en[b] & (|st[b*16 +: 16]);
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_dir = '1; m_out = '0; m_rise = '0; m_fall = '0; m_stat = '0;
         m_s1 = '0; m_s2 = '0; m_prev = '0; m_ben = '0; m_rd = '0;
      end else begin
         int code, s, w;
         logic [31:0] val, wm;
         logic [63:0] edges, w1c, ext;
         code = decode(bus_addr);
         s = (code >= 0 && code < 100) ? code / 10 : 0;
         w = (code >= 0 && code < 100) ? code % 10 : 0;
         val = '0;
         if (code == 100) val = {28'd0, m_ben};
         else if (code >= 0) begin
            case (w)
               0: val = m_dir[s*32 +: 32];
               1, 2, 3: val = m_out[s*32 +: 32];
               4: val = m_s2[s*32 +: 32];
               5, 6: val = m_rise[s*32 +: 32];
               7, 8: val = m_fall[s*32 +: 32];
               default: val = m_stat[s*32 +: 32];
            endcase
         end
         if (bus_ren) m_rd = val;
         edges = (m_s2 & ~m_prev & m_rise) | (~m_s2 & m_prev & m_fall);
         w1c = '0;
         wm = bus_wdata;
         ext = '0;
         ext[s*32 +: 32] = wm;
         if (bus_wen && code == 100) m_ben = wm[3:0];
         else if (bus_wen && code >= 0) begin
            case (w)
               0: m_dir[s*32 +: 32] = wm;
               2: m_out = m_out | ext;
               3: m_out = m_out & ~ext;
               5: m_rise = m_rise | ext;
               6: m_rise = m_rise & ~ext;
               7: m_fall = m_fall | ext;
               8: m_fall = m_fall & ~ext;
               9: w1c = ext;
               default: ;
            endcase
         end
         m_stat = (m_stat & ~w1c) | edges;
         m_prev = m_s2;
         m_s2 = m_s1;
         m_s1 = pin_in;
      end
   end

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         chk("R3 pin_out vs model", pin_out, m_out);
         chk("R2 pin_oe vs model", pin_oe, ~m_dir);
         chk("R8 irq vs model", {60'd0, irq}, {60'd0, model_irq(m_stat, m_ben)});
         chk("R9 bus_rdata vs model", {32'd0, bus_rdata}, {32'd0, m_rd});
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         total++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_ren = 1'b1;
      @(negedge clk);
      bus_ren = 1'b0;
      d = bus_rdata;
   endtask

   task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(tag, {32'd0, d}, {32'd0, exp});
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'h5EED_0042);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1'b1;

      // R1 reset state
      rdchk("R1 dir0 after reset", 8'h10, 32'hFFFF_FFFF);
      rdchk("R1 dir1 after reset", 8'h38, 32'hFFFF_FFFF);
      rdchk("R1 stat0 after reset", 8'h34, 32'h0);
      rdchk("R1 bank enable after reset", 8'h08, 32'h0);
      rdchk("R1 rise0 after reset", 8'h24, 32'h0);
      chk("R1 pin_oe after reset", pin_oe, 64'h0);
      chk("R1 pin_out after reset", pin_out, 64'h0);
      chk("R1 irq after reset", {60'd0, irq}, 64'h0);

      // R2 direction
      wr(8'h10, 32'hFFFF_FF00);
      chk("R2 low pins outputs", pin_oe, 64'h0000_0000_0000_00FF);
      rdchk("R2 dir0 readback", 8'h10, 32'hFFFF_FF00);

      // R3 set / clear ports, out word read-only
      wr(8'h18, 32'h0000_0F0F);
      rdchk("R3 set port", 8'h14, 32'h0000_0F0F);
      wr(8'h1C, 32'h0000_0003);
      rdchk("R3 clear port", 8'h14, 32'h0000_0F0C);
      wr(8'h14, 32'hFFFF_FFFF);
      rdchk("R3 out word write ignored", 8'h14, 32'h0000_0F0C);
      chk("R3 pin_out", pin_out, 64'h0000_0000_0000_0F0C);
      rdchk("R5 set port reads out data", 8'h18, 32'h0000_0F0C);
      rdchk("R5 clear port reads out data", 8'h1C, 32'h0000_0F0C);

      // R4 input readback on an output pin
      wr(8'h38, 32'hFFFF_FEFF);
      pin_in[40] = 1'b1;
      idle(3);
      rdchk("R4 input of output pin", 8'h48, 32'h0000_0100);
      wr(8'h48, 32'h0);
      rdchk("R4 input write ignored", 8'h48, 32'h0000_0100);

      // R5 edge enable ports
      wr(8'h24, 32'h8);
      wr(8'h2C, 32'h8);
      rdchk("R5 clear-rise reads rise enables", 8'h28, 32'h8);
      rdchk("R5 clear-fall reads fall enables", 8'h30, 32'h8);
      wr(8'h30, 32'h8);
      rdchk("R5 fall disabled", 8'h2C, 32'h0);

      // R6 detection, R8 interrupt
      wr(8'h08, 32'hF);
      pin_in[3] = 1'b1;
      idle(4);
      rdchk("R6 rising edge sets status", 8'h34, 32'h8);
      chk("R8 bank0 irq", {60'd0, irq}, 64'h1);
      pin_in[3] = 1'b0;
      idle(4);
      wr(8'h34, 32'h8);
      rdchk("R7 status cleared", 8'h34, 32'h0);
      chk("R8 irq low after clear", {60'd0, irq}, 64'h0);
      pin_in[5] = 1'b1;
      idle(4);
      rdchk("R6 disabled rising ignored", 8'h34, 32'h0);
      pin_in[3] = 1'b0;

      // R6 exact delay: set at third clock edge after the change
      @(negedge clk);
      pin_in[3] = 1'b1;
      idle(2);
      chk("R6 not yet set after two edges", {60'd0, irq}, 64'h0);
      idle(1);
      chk("R6 set after three edges", {60'd0, irq}, 64'h1);
      wr(8'h34, 32'h8);

      // R7 edge and clear in the same cycle
      wr(8'h2C, 32'h8);
      pin_in[3] = 1'b1;
      wr(8'h34, 32'h8);
      @(negedge clk);
      pin_in[3] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      bus_addr = 8'h34; bus_wdata = 32'h8; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
      rdchk("R7 edge beats clear", 8'h34, 32'h8);
      wr(8'h34, 32'h8);
      rdchk("R7 cleared afterwards", 8'h34, 32'h0);

      // R8 odd bank gating on set 1
      wr(8'h54, 32'h0010_0000);
      wr(8'h08, 32'h7);
      pin_in[52] = 1'b1;
      idle(4);
      pin_in[52] = 1'b0;
      idle(4);
      rdchk("R6 falling on set1 bit20", 8'h5C, 32'h0010_0000);
      chk("R8 bank3 gated off", {60'd0, irq}, 64'h0);
      wr(8'h08, 32'hF);
      chk("R8 bank3 enabled", {60'd0, irq}, 64'h8);
      rdchk("R8 bank enable readback", 8'h08, 32'hF);
      idle(3);
      chk("R10 rdata held", {32'd0, bus_rdata}, 64'hF);
      wr(8'h5C, 32'h0010_0000);

      // R9 unmapped reads
      rdchk("R9 offset 0x00", 8'h00, 32'h0);
      rdchk("R9 offset 0x0C", 8'h0C, 32'h0);
      rdchk("R9 offset 0x60", 8'h60, 32'h0);
      rdchk("R9 unaligned 0x11", 8'h11, 32'h0);

      // Random traffic checked against the model every cycle
      for (int n = 0; n < 4000; n++) begin
         int idx;
         @(negedge clk);
         idx = int'($urandom % 21);
         if ($urandom % 8 == 0) bus_addr = 8'($urandom);
         else if (idx == 20) bus_addr = 8'h08;
         else bus_addr = 8'(16 + (idx / 10) * 40 + (idx % 10) * 4);
         bus_wen = ($urandom % 3 == 0);
         bus_ren = ($urandom % 2 == 0);
         bus_wdata = $urandom & $urandom;
         pin_in = pin_in ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      end
      @(negedge clk);
      bus_wen = 1'b0; bus_ren = 1'b0;
      idle(4);
      summary();
      $finish;
   end

endmodule